// File: doc/BRIEF.md
# Pixel Region Hit Latency Buffer

This block is the digital logic of one region in a pixel matrix. Sixteen pixels, arranged as a 4x4 group, share one small hit memory. On every bunch-crossing clock each pixel presents a hit flag and a 5-bit time-over-threshold charge. In any cycle where at least one pixel fires, the block writes one event into a free slot of the shared buffer. The event holds the current timestamp, the 16-bit map of pixels that fired and their charges.

A trigger refers to the bunch crossing that happened a fixed latency earlier, which is 500 clocks by default. When a trigger arrives, the block searches for the stored event whose timestamp is exactly that many cycles old. A matching event is queued for the column readout. An event that reaches the latency age with no trigger is discarded, and its slot is reused. If every slot is occupied, a new hit event is lost and a saturating overflow counter counts the loss.

Matched events leave through a valid/ready port. The output holds each event unchanged until the column side accepts it.

Top module: `lb_region_buffer`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows `rd_valid_o` = 0, `ovf_cnt_o` = 0 and `bx_ts_o` = 0, and the buffer holds no events.
- R2: `bx_ts_o` advances by one on every clock after reset and wraps from 511 to 0.
- R3: A cycle with at least one `hit_i` bit set stores one event carrying `bx_ts_o` of that cycle, the hit map and the charges. The charge of pixel p sits at bits [5p+4:5p] of `tot_i` and of `rd_tot_o`. Charges of pixels whose hit bit is 0 are stored as zero.
- R4: When all slots are occupied at the start of a cycle with a hit, the event is dropped and `ovf_cnt_o` rises by one, saturating at its maximum. Otherwise `ovf_cnt_o` does not change.
- R5: A trigger in a cycle with timestamp C selects the stored event whose timestamp is (C − 500) mod 512, and that event is later delivered on the readout port.
- R6: A trigger with no event of exactly that age produces no output.
- R7: An event that reaches age 500 in a cycle without a trigger is discarded and is never delivered.
- R8: While `rd_valid_o` is 1 and `rd_ready_i` is 0, the output event stays unchanged in the next cycle. A matched event appears on `rd_valid_o` two clock edges after its trigger cycle when the output is idle.
- R9: A slot is freed when its event is moved to the output stage, so it can take a new hit in the next cycle.
- R10: Several matched events waiting at once are delivered one per accepted handshake, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_i | input | 16 | Per-pixel hit flags for this cycle |
| tot_i | input | 80 | Per-pixel 5-bit charges, pixel p at [5p+4:5p] |
| trig_i | input | 1 | Trigger for the crossing 500 cycles back |
| rd_ready_i | input | 1 | Column side accepts the output event |
| rd_valid_o | output | 1 | Output event is present |
| rd_ts_o | output | 9 | Timestamp of the output event |
| rd_map_o | output | 16 | Hit map of the output event |
| rd_tot_o | output | 80 | Charges of the output event |
| ovf_cnt_o | output | 8 | Saturating count of dropped hit events |
| bx_ts_o | output | 9 | Current timestamp |

## Verification
Several things can happen in the same clock edge. A new hit can be written while a trigger marks an older event for readout, and in that edge another slot can expire or move to the output stage. On top of that, a full buffer can refuse the hit in the very cycle a slot is being freed. The stimulus keeps hits running through the trigger windows and places dense hit bursts so that their triggers fall into a stretch where ready is held low. A cycle-accurate occupancy model in the bench then predicts every overflow, every valid cycle and the identity of each delivered event.

// File: rtl/lb_pkg.sv
// Package lb_pkg
// Shared definitions for the pixel region latency buffer.
// Assumes: consumers size their own vectors from module parameters.
package lb_pkg;

    // Life cycle of one buffer slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_HELD = 2'd1,
        SLOT_PEND = 2'd2
    } slot_state_e;

endpackage

// File: rtl/lb_ts_counter.sv
// Module lb_ts_counter
// Free-running bunch-crossing timestamp, wraps modulo 2**TS_W.
// Assumes: one increment per clock, cleared by synchronous reset.
module lb_ts_counter #(
    parameter int TS_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_o
);

    // Count crossings
    always_ff @(posedge clk) begin
        if (!rst_n) ts_o <= '0;
        else        ts_o <= ts_o + 1'b1;
    end

endmodule

// File: rtl/lb_slot.sv
// Module lb_slot
// One entry of the shared buffer: state, timestamp, hit map, charges.
// Assumes: wr_sel only targets a free slot; take_sel only a pending one.
// An entry at exactly LATENCY age either becomes pending (trigger) or is freed.
module lb_slot
    import lb_pkg::*;
#(
    parameter int NPIX    = 16,
    parameter int TOT_W   = 5,
    parameter int TS_W    = 9,
    parameter int LATENCY = 500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TS_W-1:0]       cur_ts,
    input  logic                  wr_sel,
    input  logic [NPIX-1:0]       wr_map,
    input  logic [NPIX*TOT_W-1:0] wr_tot,
    input  logic                  trig,
    input  logic                  take_sel,
    output logic                  free_o,
    output logic                  pend_o,
    output logic [TS_W-1:0]       ts_o,
    output logic [NPIX-1:0]       map_o,
    output logic [NPIX*TOT_W-1:0] tot_o
);

    localparam logic [TS_W-1:0] LAT_TS = TS_W'(LATENCY);

    slot_state_e     st_q;
    logic [TS_W-1:0] age;
    logic            at_lat;

    // Age of the held event relative to the current crossing
    always_comb begin
        age    = cur_ts - ts_o;
        at_lat = (st_q == SLOT_HELD) && (age == LAT_TS);
    end

    assign free_o = (st_q == SLOT_FREE);
    assign pend_o = (st_q == SLOT_PEND);

    // Slot state: write, match or expire at latency, release on take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SLOT_FREE;
        end else if (wr_sel) begin
            st_q <= SLOT_HELD;
        end else if (at_lat) begin
            st_q <= trig ? SLOT_PEND : SLOT_FREE;
        end else if (take_sel) begin
            st_q <= SLOT_FREE;
        end
    end

    // Payload capture on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_o  <= '0;
            map_o <= '0;
            tot_o <= '0;
        end else if (wr_sel) begin
            ts_o  <= cur_ts;
            map_o <= wr_map;
            tot_o <= wr_tot;
        end
    end

endmodule

// File: rtl/lb_slot_array.sv
// Module lb_slot_array
// DEPTH slots with lowest-index allocation and lowest-index readout pick.
// Assumes: wr_en is dropped by the caller when full is high.
module lb_slot_array #(
    parameter int NPIX    = 16,
    parameter int TOT_W   = 5,
    parameter int TS_W    = 9,
    parameter int DEPTH   = 8,
    parameter int LATENCY = 500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TS_W-1:0]       cur_ts,
    input  logic                  wr_en,
    input  logic [NPIX-1:0]       wr_map,
    input  logic [NPIX*TOT_W-1:0] wr_tot,
    input  logic                  trig,
    input  logic                  take,
    output logic                  full,
    output logic                  any_pend,
    output logic [TS_W-1:0]       pk_ts,
    output logic [NPIX-1:0]       pk_map,
    output logic [NPIX*TOT_W-1:0] pk_tot
);

    localparam int TOTW = NPIX * TOT_W;

    logic [DEPTH-1:0]           free_v;
    logic [DEPTH-1:0]           pend_v;
    logic [DEPTH-1:0]           free_oh;
    logic [DEPTH-1:0]           pend_oh;
    logic                       got_free;
    logic                       got_pend;
    logic [DEPTH-1:0][TS_W-1:0] ts_v;
    logic [DEPTH-1:0][NPIX-1:0] map_v;
    logic [DEPTH-1:0][TOTW-1:0] tot_v;

    // Slot instances
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        lb_slot #(
            .NPIX    (NPIX),
            .TOT_W   (TOT_W),
            .TS_W    (TS_W),
            .LATENCY (LATENCY)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_ts   (cur_ts),
            .wr_sel   (wr_en && free_oh[i]),
            .wr_map   (wr_map),
            .wr_tot   (wr_tot),
            .trig     (trig),
            .take_sel (take && pend_oh[i]),
            .free_o   (free_v[i]),
            .pend_o   (pend_v[i]),
            .ts_o     (ts_v[i]),
            .map_o    (map_v[i]),
            .tot_o    (tot_v[i])
        );
    end

    // Lowest free slot for writing, lowest pending slot for readout
    always_comb begin
        free_oh  = '0;
        pend_oh  = '0;
        got_free = 1'b0;
        got_pend = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_v[i] && !got_free) begin
                free_oh[i] = 1'b1;
                got_free   = 1'b1;
            end
            if (pend_v[i] && !got_pend) begin
                pend_oh[i] = 1'b1;
                got_pend   = 1'b1;
            end
        end
    end

    // One-hot mux of the picked pending event
    always_comb begin
        pk_ts  = '0;
        pk_map = '0;
        pk_tot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pend_oh[i]) begin
                pk_ts  = pk_ts  | ts_v[i];
                pk_map = pk_map | map_v[i];
                pk_tot = pk_tot | tot_v[i];
            end
        end
    end

    assign full     = ~got_free;
    assign any_pend = got_pend;

endmodule

// File: rtl/lb_readout.sv
// Module lb_readout
// Output register with valid/ready; loads a pending event when idle or accepted.
// Assumes: pk_* are valid whenever any_pend is high.
module lb_readout #(
    parameter int NPIX  = 16,
    parameter int TOT_W = 5,
    parameter int TS_W  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  any_pend,
    input  logic [TS_W-1:0]       pk_ts,
    input  logic [NPIX-1:0]       pk_map,
    input  logic [NPIX*TOT_W-1:0] pk_tot,
    input  logic                  rd_ready,
    output logic                  take,
    output logic                  rd_valid,
    output logic [TS_W-1:0]       rd_ts,
    output logic [NPIX-1:0]       rd_map,
    output logic [NPIX*TOT_W-1:0] rd_tot
);

    assign take = any_pend && (!rd_valid || rd_ready);

    // Output stage: refill on take, empty on accepted handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_ts    <= '0;
            rd_map   <= '0;
            rd_tot   <= '0;
        end else if (take) begin
            rd_valid <= 1'b1;
            rd_ts    <= pk_ts;
            rd_map   <= pk_map;
            rd_tot   <= pk_tot;
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/lb_region_buffer.sv
// Module lb_region_buffer
// Region-level latency buffer: timestamps hit events of NPIX pixels, keeps
// them in DEPTH shared slots, returns the one matching a trigger LATENCY
// crossings later, drops unmatched events and counts lost hits.
// Assumes: LATENCY < 2**TS_W; one trigger refers to one crossing.
module lb_region_buffer #(
    parameter int NPIX    = 16,
    parameter int TOT_W   = 5,
    parameter int TS_W    = 9,
    parameter int DEPTH   = 8,
    parameter int LATENCY = 500,
    parameter int OVF_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIX-1:0]       hit_i,
    input  logic [NPIX*TOT_W-1:0] tot_i,
    input  logic                  trig_i,
    input  logic                  rd_ready_i,
    output logic                  rd_valid_o,
    output logic [TS_W-1:0]       rd_ts_o,
    output logic [NPIX-1:0]       rd_map_o,
    output logic [NPIX*TOT_W-1:0] rd_tot_o,
    output logic [OVF_W-1:0]      ovf_cnt_o,
    output logic [TS_W-1:0]       bx_ts_o
);

    logic                  any_hit;
    logic                  slot_full;
    logic                  slot_any_pend;
    logic                  take;
    logic [NPIX*TOT_W-1:0] tot_masked;
    logic [TS_W-1:0]       pk_ts;
    logic [NPIX-1:0]       pk_map;
    logic [NPIX*TOT_W-1:0] pk_tot;

    assign any_hit = |hit_i;

    // Zero the charge of pixels that did not fire
    for (genvar p = 0; p < NPIX; p++) begin : g_mask
        assign tot_masked[p*TOT_W +: TOT_W] =
            hit_i[p] ? tot_i[p*TOT_W +: TOT_W] : '0;
    end

    lb_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .ts_o  (bx_ts_o)
    );

    lb_slot_array #(
        .NPIX    (NPIX),
        .TOT_W   (TOT_W),
        .TS_W    (TS_W),
        .DEPTH   (DEPTH),
        .LATENCY (LATENCY)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_ts   (bx_ts_o),
        .wr_en    (any_hit && !slot_full),
        .wr_map   (hit_i),
        .wr_tot   (tot_masked),
        .trig     (trig_i),
        .take     (take),
        .full     (slot_full),
        .any_pend (slot_any_pend),
        .pk_ts    (pk_ts),
        .pk_map   (pk_map),
        .pk_tot   (pk_tot)
    );

    lb_readout #(
        .NPIX  (NPIX),
        .TOT_W (TOT_W),
        .TS_W  (TS_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (slot_any_pend),
        .pk_ts    (pk_ts),
        .pk_map   (pk_map),
        .pk_tot   (pk_tot),
        .rd_ready (rd_ready_i),
        .take     (take),
        .rd_valid (rd_valid_o),
        .rd_ts    (rd_ts_o),
        .rd_map   (rd_map_o),
        .rd_tot   (rd_tot_o)
    );

    // Saturating count of hit events refused by a full buffer
    always_ff @(posedge clk) begin
        if (!rst_n)                                     ovf_cnt_o <= '0;
        else if (any_hit && slot_full && ovf_cnt_o != '1) ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end

endmodule

// File: rtl/lb_region_buffer_chk.sv
// Module lb_region_buffer_chk
// Temporal properties of lb_region_buffer, attached by bind below.
// Assumes: slot_full and slot_any_pend come from the slot array.
module lb_region_buffer_chk #(
    parameter int NPIX  = 16,
    parameter int TOT_W = 5,
    parameter int TS_W  = 9,
    parameter int OVF_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPIX-1:0]       hit_i,
    input logic                  rd_ready_i,
    input logic                  rd_valid_o,
    input logic [TS_W-1:0]       rd_ts_o,
    input logic [NPIX-1:0]       rd_map_o,
    input logic [NPIX*TOT_W-1:0] rd_tot_o,
    input logic [OVF_W-1:0]      ovf_cnt_o,
    input logic [TS_W-1:0]       bx_ts_o,
    input logic                  slot_full,
    input logic                  slot_any_pend
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid_o && ovf_cnt_o == '0 && bx_ts_o == '0));

    assert_ts_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> bx_ts_o == TS_W'($past(bx_ts_o) + 1'b1));

    assert_ovf_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i && slot_full && ovf_cnt_o != '1) |=> ovf_cnt_o == OVF_W'($past(ovf_cnt_o) + 1'b1));

    assert_ovf_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit_i && slot_full) |=> $stable(ovf_cnt_o));

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=>
            (rd_valid_o && $stable(rd_ts_o) && $stable(rd_map_o) && $stable(rd_tot_o)));

    assert_out_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> $past(slot_any_pend));

endmodule

bind lb_region_buffer lb_region_buffer_chk #(
    .NPIX  (NPIX),
    .TOT_W (TOT_W),
    .TS_W  (TS_W),
    .OVF_W (OVF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit_i         (hit_i),
    .rd_ready_i    (rd_ready_i),
    .rd_valid_o    (rd_valid_o),
    .rd_ts_o       (rd_ts_o),
    .rd_map_o      (rd_map_o),
    .rd_tot_o      (rd_tot_o),
    .ovf_cnt_o     (ovf_cnt_o),
    .bx_ts_o       (bx_ts_o),
    .slot_full     (slot_full),
    .slot_any_pend (slot_any_pend)
);

// File: tb/sim_lb_region_buffer.sv
// Bench for lb_region_buffer: random hits, triggers and ready, with dense
// directed bursts, checked against an occupancy model keyed by timestamp.
module sim_lb_region_buffer;

    localparam int NPIX  = 16;
    localparam int TOT_W = 5;
    localparam int TS_W  = 9;
    localparam int DEPTH = 8;
    localparam int LAT   = 500;
    localparam int OVF_W = 8;
    localparam int TOTW  = NPIX * TOT_W;
    localparam int NCYC  = 6000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIX-1:0] hit = '0;
    logic [TOTW-1:0] tot = '0;
    logic            trig = 1'b0;
    logic            rdy = 1'b0;
    logic            rd_valid;
    logic [TS_W-1:0] rd_ts;
    logic [NPIX-1:0] rd_map;
    logic [TOTW-1:0] rd_tot;
    logic [OVF_W-1:0] ovf;
    logic [TS_W-1:0] bx_ts;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    lb_region_buffer #(
        .NPIX(NPIX), .TOT_W(TOT_W), .TS_W(TS_W),
        .DEPTH(DEPTH), .LATENCY(LAT), .OVF_W(OVF_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .tot_i(tot), .trig_i(trig),
        .rd_ready_i(rdy), .rd_valid_o(rd_valid), .rd_ts_o(rd_ts),
        .rd_map_o(rd_map), .rd_tot_o(rd_tot), .ovf_cnt_o(ovf), .bx_ts_o(bx_ts)
    );

    // Model state per timestamp: 0 none, 1 stored, 2 triggered
    int              m_st  [512];
    logic [NPIX-1:0] m_map [512];
    logic [TOTW-1:0] m_tot [512];
    logic [TS_W-1:0] m_ts;
    int  m_occ, m_pend, m_ovf;
    bit  m_ov;
    int  n_trig, n_deliv;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [TOTW-1:0] mask_tot(input logic [NPIX-1:0] m,
                                                 input logic [TOTW-1:0] t);
        logic [TOTW-1:0] r = '0;
        for (int p = 0; p < NPIX; p++)
            if (m[p]) r[p*TOT_W +: TOT_W] = t[p*TOT_W +: TOT_W];
        return r;
    endfunction

    // Advance the model by one clock edge with the inputs now driven
    task automatic model_step();
        logic [TS_W-1:0] tgt;
        int occ_b, pend_b;
        tgt    = m_ts - TS_W'(LAT);
        occ_b  = m_occ;
        pend_b = m_pend;
        if ((!m_ov || rdy) && pend_b > 0) begin
            m_ov = 1'b1; m_pend--; m_occ--;
        end else if (rdy) begin
            m_ov = 1'b0;
        end
        if (m_st[tgt] == 1) begin
            if (trig) begin m_st[tgt] = 2; m_pend++; n_trig++; end
            else      begin m_st[tgt] = 0; m_occ--; end
        end
        if (|hit) begin
            if (occ_b == DEPTH) begin
                if (m_ovf != (1 << OVF_W) - 1) m_ovf++;
            end else begin
                m_st[m_ts]  = 1;
                m_map[m_ts] = hit;
                m_tot[m_ts] = mask_tot(hit, tot);
                m_occ++;
            end
        end
        m_ts = m_ts + 1'b1;
    endtask

    initial begin : main
        logic [TS_W-1:0] tgt;
        bit              prev_hold;
        logic [TS_W-1:0] h_ts;
        logic [NPIX-1:0] h_map;
        logic [TOTW-1:0] h_tot;
        void'($urandom(32'd20160927));
        for (int i = 0; i < 512; i++) m_st[i] = 0;
        m_ts = '0; m_occ = 0; m_pend = 0; m_ovf = 0; m_ov = 1'b0;
        n_trig = 0; n_deliv = 0; prev_hold = 1'b0;
        h_ts = '0; h_map = '0; h_tot = '0;

        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "reset valid", 96'(rd_valid), 0);
        chk(ovf == '0, "R1", "reset overflow", 96'(ovf), 0);
        chk(bx_ts == '0, "R1", "reset timestamp", 96'(bx_ts), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NCYC + 700; cyc++) begin
            // Outputs after the previous edge
            chk(bx_ts == m_ts, "R2", "timestamp", 96'(bx_ts), 96'(m_ts));
            chk(ovf == OVF_W'(m_ovf), "R4/R9", "overflow count", 96'(ovf), 96'(m_ovf));
            chk(rd_valid == m_ov, "R5/R6/R7/R8", "output valid", 96'(rd_valid), 96'(m_ov));
            if (prev_hold) begin
                chk(rd_ts == h_ts && rd_map == h_map && rd_tot == h_tot, "R8",
                    "held output", 96'(rd_ts), 96'(h_ts));
            end

            // New stimulus
            tgt = m_ts - TS_W'(LAT);
            hit = '0;
            tot = '0;
            if (cyc < NCYC) begin
                if ((cyc >= 1000 && cyc < 1030) || (cyc >= 3000 && cyc < 3012) ||
                    ($urandom % 100 < 2)) begin
                    hit = NPIX'($urandom) | (NPIX'(1) << ($urandom % NPIX));
                    for (int p = 0; p < NPIX; p++) tot[p*TOT_W +: TOT_W] = TOT_W'($urandom);
                end
                if (m_st[tgt] == 1) trig = ($urandom % 10 < 6);
                else                trig = ($urandom % 100 < 3);
                if (cyc >= 1505 && cyc < 1513) rdy = 1'b0;
                else                           rdy = ($urandom % 100 < 80);
            end else begin
                trig = 1'b0;
                rdy  = 1'b1;
            end

            // Handshake at the coming edge: identify and compare the event
            if (rd_valid && rdy) begin
                chk(m_st[rd_ts] == 2, "R6/R7", "delivered event was triggered",
                    96'(m_st[rd_ts]), 2);
                if (m_st[rd_ts] == 2) begin
                    chk(rd_map == m_map[rd_ts], "R3", "hit map", 96'(rd_map), 96'(m_map[rd_ts]));
                    chk(rd_tot == m_tot[rd_ts], "R3", "charges", 96'(rd_tot), 96'(m_tot[rd_ts]));
                    m_st[rd_ts] = 0;
                    n_deliv++;
                end
            end
            prev_hold = rd_valid && !rdy;
            h_ts = rd_ts; h_map = rd_map; h_tot = rd_tot;

            model_step();
            @(negedge clk);
        end

        chk(n_deliv == n_trig, "R5/R10", "delivered vs matched triggers",
            96'(n_deliv), 96'(n_trig));
        chk(m_pend == 0 && !rd_valid, "R10", "drained", 96'(m_pend), 0);
        chk(m_ovf > 0, "R4", "overflow provoked", 96'(m_ovf), 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule